// File: doc/BRIEF.md
# Look-ahead Bit Fetcher for a One-Bin-per-Cycle Arithmetic Decoder

This block feeds raw bitstream bits to an arithmetic decode engine that resolves one bin per clock. It shows the engine three look-ahead views of the stream at once. The first is the next single bit. The second is an 8-bit view that starts after that bit, if the engine takes it. The third is a 32-bit view that starts after the bits the engine takes from the 8-bit view. In the same cycle the engine reports how many bits it takes from each view. The fetcher then advances by their sum on the next rising edge. No cycle is ever lost to a refill.

The stream lives in a word-addressed memory of 64-bit words. Word `a` precedes word `a+1`, and within a word bit 63 comes first. A current word, a following word and a read-ahead word are kept in registers. A 6-bit position counter marks how far into the current word the stream has been consumed. When an advance carries the position past a word boundary, the words shift down by one and a single memory read is issued for the next word. The memory answers one cycle after a read is requested. The memory side has no back-pressure.

A `start` pulse restarts the fetcher at address 0. It then spends four cycles priming before `bits_valid` rises. While `bits_valid` is low the consumption counts are ignored. Once `bits_valid` is high it stays high until the next `start` or reset, because the fetcher never stalls.

Top module: `bitf_fetch`

## Requirements
- R1: After synchronous reset `bits_valid` and `rd_en` are low, and they stay low until `start` is sampled.
- R2: In the three cycles after the edge that samples `start`, `rd_en` is high with `rd_addr` equal to 0, 1 and 2. The cycle after that has no read. `bits_valid` is high from the fifth cycle on.
- R3: While valid, `peek_one` equals the next unconsumed stream bit. Stream order is ascending word address, and within a word bit 63 comes first.
- R4: While valid, `peek_mid[7]` down to `peek_mid[0]` are the 8 stream bits that follow the next `take_one` bits (0 or 1).
- R5: While valid, `peek_wide[31]` down to `peek_wide[0]` are the 32 stream bits that follow the next `take_one` + `take_mid` bits.
- R6: Each valid cycle advances the stream by `take_one` + `take_mid` + `take_wide` at the next edge. With all three counts at zero, the views are unchanged in the following cycle.
- R7: A `take_mid` above 8 counts as 8, and a `take_wide` above 32 counts as 32, both for the 32-bit view and for the advance.
- R8: `rd_en` is high in exactly those valid cycles whose advance crosses a 64-bit word boundary. Those reads use consecutive addresses starting at 3. This holds with no stall at a sustained 41 bits per cycle, including boundary crossings on back-to-back cycles.
- R9: While `bits_valid` is low, all three views read zero and the consumption counts have no effect on the stream position.
- R10: A `start` pulse during operation discards the current position and restarts from address 0 with the R2 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin or restart priming from address 0 |
| take_one | input | 1 | Bits taken from the 1-bit view this cycle |
| take_mid | input | 4 | Bits taken from the 8-bit view (0..8, clamped) |
| take_wide | input | 6 | Bits taken from the 32-bit view (0..32, clamped) |
| bits_valid | output | 1 | Views hold live stream data |
| peek_one | output | 1 | Next stream bit |
| peek_mid | output | 8 | 8 bits after the 1-bit consumption |
| peek_wide | output | 32 | 32 bits after the 1-bit and 8-bit consumption |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory word address |
| rd_data | input | 64 | Memory word, valid the cycle after `rd_en` |

## Verification
A wrong position counter shows up in the very next valid cycle. All three views shift against the modelled stream, and `rd_en` fires a cycle early or late against the boundary crossings. A word that shifts out of order, or a read-ahead word captured at the wrong time, does not show at once. It surfaces only once the consumed position enters that word, up to two words later. For that reason the bench runs long stretches at the maximum rate of 41 bits and compares every view against a stream model in every cycle. A clamping fault appears as a wrong 32-bit view in the same cycle and as a position error in every cycle after it.

// File: rtl/bitf_pkg.sv
package bitf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RUN  = 2'd2
  } bitf_state_t;

  // words fetched before the views go live: current, following, read-ahead
  localparam int unsigned PRIME_WORDS = 3;
endpackage

// File: rtl/bitf_tap.sv
module bitf_tap #(
  parameter int WORD_W = 64,
  parameter int MID    = 8,
  parameter int WIDE   = 32,
  parameter int POS_W  = 6,
  parameter int MID_CW = 4
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] pre,
  input  logic [POS_W-1:0]  pos,
  input  logic              take_one,
  input  logic [MID_CW-1:0] k_mid,
  output logic              peek_one,
  output logic [MID-1:0]    peek_mid,
  output logic [WIDE-1:0]   peek_wide
);
  logic [WORD_W-1:0] win;
  logic [WORD_W-1:0] after_one;
  logic [WORD_W-1:0] after_mid;

  always_comb begin
    // 64-bit window aligned to the next unconsumed bit
    win = cur << pos;
    if (pos != '0)
      win = win | (pre >> (WORD_W - int'(pos)));
    after_one = take_one ? {win[WORD_W-2:0], 1'b0} : win;
    after_mid = after_one << k_mid;
    peek_one  = valid & win[WORD_W-1];
    peek_mid  = valid ? MID'(after_one >> (WORD_W - MID)) : '0;
    peek_wide = valid ? WIDE'(after_mid >> (WORD_W - WIDE)) : '0;
  end
endmodule

// File: rtl/bitf_ctrl.sv
module bitf_ctrl
  import bitf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int POS_W   = 6,
  parameter int MID_CW  = 4,
  parameter int WIDE_CW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               take_one,
  input  logic [MID_CW-1:0]  k_mid,
  input  logic [WIDE_CW-1:0] k_wide,
  output logic               valid,
  output logic [POS_W-1:0]   pos,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_pend,
  output logic               load_cur,
  output logic               load_pre,
  output logic               advance
);
  localparam int CW = POS_W + 1;

  bitf_state_t        st;
  logic [1:0]         fill_cnt;
  logic [POS_W-1:0]   pos_q;
  logic [ADDR_W-1:0]  adr_q;
  logic               pend_q;
  logic [CW-1:0]      used;
  logic [CW-1:0]      sum;
  logic               filling;
  logic               fill_fetch;

  always_comb begin
    used       = CW'(take_one) + CW'(k_mid) + CW'(k_wide);
    sum        = CW'(pos_q) + used;
    filling    = (st == ST_FILL) & ~start;
    fill_fetch = filling & (fill_cnt < 2'(PRIME_WORDS));
    advance    = (st == ST_RUN) & ~start & sum[POS_W];
    load_cur   = filling & (fill_cnt == 2'd1);
    load_pre   = filling & (fill_cnt == 2'd2);
    rd_en      = advance | fill_fetch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      fill_cnt <= '0;
      pos_q    <= '0;
      adr_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      pend_q <= rd_en;
      if (rd_en)
        adr_q <= adr_q + 1'b1;
      if (start) begin
        st       <= ST_FILL;
        fill_cnt <= '0;
        pos_q    <= '0;
        adr_q    <= '0;
      end else begin
        case (st)
          ST_FILL: begin
            fill_cnt <= fill_cnt + 1'b1;
            if (fill_cnt == 2'(PRIME_WORDS))
              st <= ST_RUN;
          end
          ST_RUN:  pos_q <= sum[POS_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign valid   = (st == ST_RUN);
  assign pos     = pos_q;
  assign rd_addr = adr_q;
  assign rd_pend = pend_q;
endmodule

// File: rtl/bitf_words.sv
module bitf_words #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              rd_pend,
  input  logic              load_cur,
  input  logic              load_pre,
  input  logic              advance,
  output logic [WORD_W-1:0] cur,
  output logic [WORD_W-1:0] pre
);
  logic [WORD_W-1:0] ahd;
  logic [WORD_W-1:0] ahd_eff;

  // a word landing this cycle can be shifted straight into the following slot
  assign ahd_eff = rd_pend ? rd_data : ahd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      pre <= '0;
      ahd <= '0;
    end else begin
      if (rd_pend)
        ahd <= rd_data;
      if (load_cur)
        cur <= rd_data;
      if (load_pre)
        pre <= rd_data;
      if (advance) begin
        cur <= pre;
        pre <= ahd_eff;
      end
    end
  end
endmodule

// File: rtl/bitf_fetch.sv
module bitf_fetch #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 16,
  parameter int MID    = 8,
  parameter int WIDE   = 32,
  localparam int POS_W   = $clog2(WORD_W),
  localparam int MID_CW  = $clog2(MID + 1),
  localparam int WIDE_CW = $clog2(WIDE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               take_one,
  input  logic [MID_CW-1:0]  take_mid,
  input  logic [WIDE_CW-1:0] take_wide,
  output logic               bits_valid,
  output logic               peek_one,
  output logic [MID-1:0]     peek_mid,
  output logic [WIDE-1:0]    peek_wide,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [WORD_W-1:0]  rd_data
);
  logic [MID_CW-1:0]  k_mid;
  logic [WIDE_CW-1:0] k_wide;
  logic [POS_W-1:0]   pos;
  logic [WORD_W-1:0]  cur;
  logic [WORD_W-1:0]  pre;
  logic               rd_pend;
  logic               load_cur;
  logic               load_pre;
  logic               advance;

  assign k_mid  = (take_mid  > MID_CW'(MID))   ? MID_CW'(MID)   : take_mid;
  assign k_wide = (take_wide > WIDE_CW'(WIDE)) ? WIDE_CW'(WIDE) : take_wide;

  bitf_ctrl #(
    .ADDR_W (ADDR_W),
    .POS_W  (POS_W),
    .MID_CW (MID_CW),
    .WIDE_CW(WIDE_CW)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .take_one(take_one),
    .k_mid   (k_mid),
    .k_wide  (k_wide),
    .valid   (bits_valid),
    .pos     (pos),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_pend (rd_pend),
    .load_cur(load_cur),
    .load_pre(load_pre),
    .advance (advance)
  );

  bitf_words #(.WORD_W(WORD_W)) u_words (
    .clk     (clk),
    .rst     (rst),
    .rd_data (rd_data),
    .rd_pend (rd_pend),
    .load_cur(load_cur),
    .load_pre(load_pre),
    .advance (advance),
    .cur     (cur),
    .pre     (pre)
  );

  bitf_tap #(
    .WORD_W(WORD_W),
    .MID   (MID),
    .WIDE  (WIDE),
    .POS_W (POS_W),
    .MID_CW(MID_CW)
  ) u_tap (
    .valid    (bits_valid),
    .cur      (cur),
    .pre      (pre),
    .pos      (pos),
    .take_one (take_one),
    .k_mid    (k_mid),
    .peek_one (peek_one),
    .peek_mid (peek_mid),
    .peek_wide(peek_wide)
  );
endmodule

// File: rtl/bitf_fetch_chk.sv
module bitf_fetch_chk #(
  parameter int ADDR_W  = 16,
  parameter int MID     = 8,
  parameter int WIDE    = 32,
  parameter int MID_CW  = 4,
  parameter int WIDE_CW = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               take_one,
  input logic [MID_CW-1:0]  take_mid,
  input logic [WIDE_CW-1:0] take_wide,
  input logic               bits_valid,
  input logic               peek_one,
  input logic [MID-1:0]     peek_mid,
  input logic [WIDE-1:0]    peek_wide,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bits_valid && !rd_en));

  assert_start_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (rd_en && rd_addr == '0));

  assert_mid_follows_one_R4: assert property (@(posedge clk) disable iff (rst)
    (bits_valid && !take_one) |-> (peek_mid[MID-1] == peek_one));

  assert_wide_follows_mid_R5: assert property (@(posedge clk) disable iff (rst)
    (bits_valid && !take_one && take_mid == '0) |-> (peek_wide[WIDE-1 -: MID] == peek_mid));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (bits_valid && !start && !take_one && take_mid == '0 && take_wide == '0)
      |=> (bits_valid && peek_one == $past(peek_one) && $stable(rd_addr)));

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (rst)
    (bits_valid && rd_en && !start) |=> (rd_addr == $past(rd_addr) + 1'b1));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (bits_valid && !rd_en && !start) |=> $stable(rd_addr));

  assert_dark_views_R9: assert property (@(posedge clk) disable iff (rst)
    !bits_valid |-> (!peek_one && peek_mid == '0 && peek_wide == '0));
endmodule

bind bitf_fetch bitf_fetch_chk #(
  .ADDR_W (ADDR_W),
  .MID    (MID),
  .WIDE   (WIDE),
  .MID_CW (MID_CW),
  .WIDE_CW(WIDE_CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .take_one  (take_one),
  .take_mid  (take_mid),
  .take_wide (take_wide),
  .bits_valid(bits_valid),
  .peek_one  (peek_one),
  .peek_mid  (peek_mid),
  .peek_wide (peek_wide),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr)
);

// File: tb/tb_bitf_fetch.sv
`timescale 1ns/1ps
module tb_bitf_fetch;
  localparam int NSTIM = 20;
  // {take_one, take_mid[3:0], take_wide[5:0]}
  localparam logic [10:0] STIM [0:NSTIM-1] = '{
    {1'b1, 4'd8,  6'd32}, {1'b0, 4'd0, 6'd0},  {1'b1, 4'd0, 6'd0},  {1'b0, 4'd3, 6'd0},
    {1'b0, 4'd0,  6'd17}, {1'b1, 4'd8, 6'd32}, {1'b1, 4'd8, 6'd32}, {1'b1, 4'd8, 6'd32},
    {1'b0, 4'd15, 6'd63}, {1'b1, 4'd9, 6'd33}, {1'b0, 4'd8, 6'd32}, {1'b1, 4'd1, 6'd1},
    {1'b0, 4'd0,  6'd0},  {1'b1, 4'd5, 6'd20}, {1'b0, 4'd7, 6'd31}, {1'b1, 4'd8, 6'd32},
    {1'b1, 4'd2,  6'd11}, {1'b0, 4'd8, 6'd0},  {1'b0, 4'd0, 6'd32}, {1'b1, 4'd8, 6'd32}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        take_one = 1'b0;
  logic [3:0]  take_mid = '0;
  logic [5:0]  take_wide = '0;
  logic        bits_valid, peek_one, rd_en;
  logic [7:0]  peek_mid;
  logic [31:0] peek_wide;
  logic [15:0] rd_addr;
  logic [63:0] rd_data = '0;

  int checks = 0;
  int fails  = 0;
  int bp     = 0;
  int exp_addr = 3;
  logic [31:0] held;

  always #10 clk = ~clk;

  bitf_fetch dut (
    .clk(clk), .rst(rst), .start(start), .take_one(take_one),
    .take_mid(take_mid), .take_wide(take_wide), .bits_valid(bits_valid),
    .peek_one(peek_one), .peek_mid(peek_mid), .peek_wide(peek_wide),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [63:0] mw(input int a);
    logic [31:0] h;
    h = 32'(a) * 32'h9E3779B1 + 32'h7F4A7C15;
    return {h, h ^ 32'hA5A50F0F ^ (32'(a) << 7)};
  endfunction

  function automatic logic sbit(input int i);
    logic [63:0] w;
    w = mw(i / 64);
    return w[63 - (i % 64)];
  endfunction

  function automatic logic [31:0] sbits(input int p, input int k);
    logic [31:0] r = '0;
    for (int j = 0; j < k; j++) r = {r[30:0], sbit(p + j)};
    return r;
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mw(int'(rd_addr));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prime();
    @(negedge clk); start = 1'b1; take_one = 1'b1; take_mid = 4'd8; take_wide = 6'd32;
    @(negedge clk); start = 1'b0; #1;
    chk(rd_en && rd_addr == 16'd0, "R2 read 0", {47'd0, rd_en, rd_addr}, {47'd0, 1'b1, 16'd0});
    for (int i = 1; i < 3; i++) begin
      @(negedge clk); #1;
      chk(rd_en && rd_addr == 16'(i), "R2 read seq", {47'd0, rd_en, rd_addr}, {47'd0, 1'b1, 16'(i)});
    end
    @(negedge clk); #1;
    chk(!rd_en && !bits_valid, "R2/R9 gap cycle", {62'd0, rd_en, bits_valid}, 64'd0);
    chk(peek_wide == '0 && peek_mid == '0 && !peek_one, "R9 dark views", {32'd0, peek_wide}, 64'd0);
    @(negedge clk); take_one = 1'b0; take_mid = '0; take_wide = '0; #1;
    chk(bits_valid, "R2 valid rises", {63'd0, bits_valid}, 64'd1);
    bp = 0;
    exp_addr = 3;
  endtask

  task automatic step(input logic t1, input logic [3:0] t8, input logic [5:0] t32);
    int k8, k32, n;
    bit crs;
    @(negedge clk); take_one = t1; take_mid = t8; take_wide = t32; #1;
    k8  = (t8 > 4'd8) ? 8 : int'(t8);
    k32 = (t32 > 6'd32) ? 32 : int'(t32);
    n   = int'(t1) + k8 + k32;
    crs = ((bp % 64) + n) >= 64;
    chk(peek_one == sbit(bp), "R3 one-bit view", {63'd0, peek_one}, {63'd0, sbit(bp)});
    chk(peek_mid == sbits(bp + int'(t1), 8)[7:0], "R4 8-bit view", {56'd0, peek_mid}, {32'd0, sbits(bp + int'(t1), 8)});
    chk(peek_wide == sbits(bp + int'(t1) + k8, 32), "R5 R7 32-bit view",
        {32'd0, peek_wide}, {32'd0, sbits(bp + int'(t1) + k8, 32)});
    chk(rd_en == crs, "R8 read on crossing", {63'd0, rd_en}, {63'd0, crs});
    if (crs) begin
      chk(rd_addr == 16'(exp_addr), "R8 read address", {48'd0, rd_addr}, 64'(exp_addr));
      exp_addr++;
    end
    bp += n;
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!bits_valid && !rd_en, "R1 reset state", {62'd0, bits_valid, rd_en}, 64'd0);
    // R9: counts before start are ignored
    @(negedge clk); take_one = 1'b1; take_mid = 4'd8; take_wide = 6'd32; #1;
    chk(!bits_valid && !rd_en && peek_wide == '0, "R9 ignored while idle",
        {31'd0, bits_valid, peek_wide}, 64'd0);
    @(negedge clk); #1;
    chk(!rd_en, "R1 no read before start", {63'd0, rd_en}, 64'd0);
    prime();

    // table walk, repeated to cover many positions
    for (int rep = 0; rep < 6; rep++)
      for (int i = 0; i < NSTIM; i++)
        step(STIM[i][10], STIM[i][9:6], STIM[i][5:0]);

    // R6: zero consumption keeps views
    step(1'b0, 4'd0, 6'd0);
    held = peek_wide;
    step(1'b0, 4'd0, 6'd0);
    chk(peek_wide == held, "R6 zero advance holds", {32'd0, peek_wide}, {32'd0, held});

    // R8: sustained maximum rate with back-to-back crossings
    for (int i = 0; i < 300; i++) step(1'b1, 4'd8, 6'd32);

    // R7: both clamps together at maximum
    for (int i = 0; i < 40; i++) step(1'b1, 4'd15, 6'd63);

    // R10: restart mid-stream, then resume from the beginning
    for (int i = 0; i < 5; i++) step(1'b0, 4'd7, 6'd13);
    prime();
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < NSTIM; j++)
        step(STIM[j][10], STIM[j][9:6], STIM[j][5:0]);
    chk(bits_valid, "R10 valid after restart", {63'd0, bits_valid}, 64'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule